// File: doc/BRIEF.md
# Word-at-a-time CRC register

This block advances a cyclic-redundancy-check register by one whole data word in every clock cycle in which the word is marked valid. Without it, the data word would have to be fed through a linear feedback shift register one bit per cycle. The generator polynomial, the register width and the data word width are all parameters, so a single description covers any CRC. The register width runs from 1 to 1024 bits and the word width from 1 to 1024 bits.

The next state is linear in the current state and the data word. At elaboration time the block works out the response of a serial shift register, over a whole word, to each single state bit and to each single data bit. It then builds every next-state bit as an XOR of the state bits and data bits whose responses reach that position.

A packet engine instantiates the block next to its datapath and raises the valid strobe with each payload word. It reads the register when the frame ends. Bit reflection of the result, any final inversion and frame delimiting all belong to the surrounding logic.

Top module: `crc_par_step`

## Requirements
- R1: A synchronous reset loads the CRC register with all ones at the clock edge where reset is sampled high, whether or not the valid strobe is also high.
- R2: While the valid strobe is low and reset is low, the register keeps its value, whatever the data input does.
- R3: When valid is high at a clock edge, the register takes the value a serial Galois shift register reaches after one shift per data bit. Each shift works as follows:
  - The feedback is register bit N-1 XOR the incoming bit.
  - The register shifts left by one.
  - Where the feedback is 1, the register is XORed with the polynomial.
- R4: Within a word, the most significant data bit `data_in[DW-1]` enters the serial shift first and bit 0 enters last.
- R5: Bit i of the `POLY` parameter is the coefficient of x^i, and the x^N term is implicit. For example, N=5 with `POLY` = 0x05 gives x^5+x^2+1.
- R6: The updated value is visible on `crc_out` after the same clock edge that sampled the valid word. Valid words on consecutive cycles each build on the previous result with no gap.
- R7: The block works for any register width and word width. The cases checked are:
  - N=5, M=8
  - N=32, M=8
  - N=32, M=32
  - N=16, M=1

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, presets the register to all ones |
| data_vld | input | 1 | The data word is valid and is absorbed at this edge |
| data_in | input | DW | Data word, bit DW-1 absorbed first |
| crc_out | output | PW | Current CRC register |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it: one register separates inputs from `crc_out`, and nothing lies beyond it. The bench changes inputs on the falling edge and waits one rising edge. It then compares `crc_out` on the following falling edge against its own serial model, which it has advanced once for each word sampled with valid high. A held cycle leaves the model unchanged, and a reset sets it to all ones. Each expected value is therefore tied to the same edge at which the register changes.

// File: rtl/crc_step_pkg.sv
package crc_step_pkg;

  localparam int MAX_W = 1024;
  typedef logic [MAX_W-1:0] wide_t;

  // Mask of the low pw bits; for pw == MAX_W the shift wraps to zero and the
  // subtraction yields all ones, which is what is wanted.
  function automatic wide_t low_bits(input int pw);
    return (wide_t'(1) << pw) - wide_t'(1);
  endfunction

  // One serial Galois shift of a pw-bit register with one incoming bit.
  function automatic wide_t lfsr_tick(input wide_t st, input wide_t poly,
                                      input int pw, input logic bit_in);
    logic  fb;
    wide_t nx;
    fb = st[pw-1] ^ bit_in;
    nx = (st << 1) & low_bits(pw);
    if (fb) nx = nx ^ (poly & low_bits(pw));
    return nx;
  endfunction

  // A whole word of dw bits, most significant bit first.
  function automatic wide_t lfsr_word(input wide_t st, input wide_t data,
                                      input wide_t poly, input int pw,
                                      input int dw);
    wide_t s;
    s = st;
    for (int i = 0; i < dw; i++) begin
      s = lfsr_tick(s, poly, pw, data[dw-1-i]);
    end
    return s;
  endfunction

endpackage

// File: rtl/crc_mask_xor.sv
module crc_mask_xor #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   MASK = '0
) (
  input  logic [W-1:0] vec,
  output logic         par
);
  always_comb par = ^(vec & MASK);
endmodule

// File: rtl/crc_lane.sv
module crc_lane #(
  parameter int              PW    = 32,
  parameter int              DW    = 32,
  parameter logic [PW-1:0]   SMASK = '0,
  parameter logic [DW-1:0]   DMASK = '0
) (
  input  logic [PW-1:0] state,
  input  logic [DW-1:0] data,
  output logic          nxt_bit
);
  logic from_state;
  logic from_data;

  crc_mask_xor #(.W(PW), .MASK(SMASK)) u_sx (.vec(state), .par(from_state));
  crc_mask_xor #(.W(DW), .MASK(DMASK)) u_dx (.vec(data),  .par(from_data));

  always_comb nxt_bit = from_state ^ from_data;
endmodule

// File: rtl/crc_hold_reg.sv
module crc_hold_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '1;
    else if (en) q <= d;
  end
endmodule

// File: rtl/crc_par_step.sv
module crc_par_step #(
  parameter int            PW   = 32,
  parameter int            DW   = 32,
  parameter logic [PW-1:0] POLY = 32'h04C11DB7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_vld,
  input  logic [DW-1:0] data_in,
  output logic [PW-1:0] crc_out
);
  import crc_step_pkg::*;

  localparam wide_t POLY_W = wide_t'(POLY);

  // Which current-state bits reach next-state bit n after one word.
  function automatic logic [PW-1:0] state_mask(input int n);
    logic [PW-1:0] m;
    wide_t         r;
    m = '0;
    for (int k = 0; k < PW; k++) begin
      r    = lfsr_word(wide_t'(1) << k, '0, POLY_W, PW, DW);
      m[k] = r[n];
    end
    return m;
  endfunction

  // Which data bits reach next-state bit n; a data bit at index j is fed at
  // serial step DW-1-j, which gives the mirrored row order.
  function automatic logic [DW-1:0] data_mask(input int n);
    logic [DW-1:0] m;
    wide_t         r;
    m = '0;
    for (int j = 0; j < DW; j++) begin
      r    = lfsr_word('0, wide_t'(1) << j, POLY_W, PW, DW);
      m[j] = r[n];
    end
    return m;
  endfunction

  logic [PW-1:0] nxt_state;
  logic          upd_fire;

  always_comb upd_fire = data_vld & ~rst;

  for (genvar n = 0; n < PW; n++) begin : g_lane
    localparam logic [PW-1:0] SM = state_mask(n);
    localparam logic [DW-1:0] DM = data_mask(n);
    crc_lane #(.PW(PW), .DW(DW), .SMASK(SM), .DMASK(DM)) u_lane (
      .state  (crc_out),
      .data   (data_in),
      .nxt_bit(nxt_state[n])
    );
  end

  crc_hold_reg #(.W(PW)) u_reg (
    .clk(clk),
    .rst(rst),
    .en (data_vld),
    .d  (nxt_state),
    .q  (crc_out)
  );
endmodule

// File: rtl/crc_step_chk.sv
module crc_step_chk #(
  parameter int            PW   = 32,
  parameter int            DW   = 32,
  parameter logic [PW-1:0] POLY = 32'h04C11DB7
) (
  input logic          clk,
  input logic          rst,
  input logic          data_vld,
  input logic [DW-1:0] data_in,
  input logic [PW-1:0] crc_out,
  input logic [PW-1:0] nxt_state,
  input logic          upd_fire
);
  import crc_step_pkg::*;

  localparam wide_t POLY_W = wide_t'(POLY);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // Superposition form: zero-data run of the state plus a lone leading 1.
  function automatic logic [PW-1:0] top_bit_response(input logic [PW-1:0] s);
    wide_t a, b;
    a = lfsr_word(wide_t'(s), '0, POLY_W, PW, DW);
    b = lfsr_word('0, wide_t'(1) << (DW - 1), POLY_W, PW, DW);
    return PW'(a ^ b);
  endfunction

  p_ones_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (crc_out == {PW{1'b1}}));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(data_vld) && !$past(rst)) |-> $stable(crc_out));

  p_serial_match_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(data_vld) && !$past(rst)) |->
      (crc_out == PW'(lfsr_word(wide_t'($past(crc_out)), wide_t'($past(data_in)),
                                POLY_W, PW, DW))));

  p_msb_first_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(data_vld) && !$past(rst) && ($past(data_in) == (DW'(1) << (DW - 1)))) |->
      (crc_out == top_bit_response($past(crc_out))));

  p_fire_lands_r6: assert property (@(posedge clk) disable iff (rst)
    upd_fire |=> (crc_out == $past(nxt_state)));
endmodule

bind crc_par_step crc_step_chk #(.PW(PW), .DW(DW), .POLY(POLY)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .data_vld (data_vld),
  .data_in  (data_in),
  .crc_out  (crc_out),
  .nxt_state(nxt_state),
  .upd_fire (upd_fire)
);

// File: tb/test_crc_par_step.sv
module test_crc_par_step;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld = 1'b0;
  logic [31:0] d32 = '0;
  logic [7:0]  d8a = '0;
  logic [7:0]  d8b = '0;
  logic [0:0]  d1  = '0;

  logic [31:0] q32;
  logic [4:0]  q5;
  logic [31:0] q328;
  logic [15:0] q16;

  int checks = 0;
  int errors = 0;

  logic [31:0] m32, m5, m328, m16;

  always #2.5 clk = ~clk;

  crc_par_step #(.PW(32), .DW(32), .POLY(32'h04C11DB7)) i_crc_par_step (
    .clk(clk), .rst(rst), .data_vld(vld), .data_in(d32), .crc_out(q32));
  crc_par_step #(.PW(5), .DW(8), .POLY(5'h05)) u_c5 (
    .clk(clk), .rst(rst), .data_vld(vld), .data_in(d8a), .crc_out(q5));
  crc_par_step #(.PW(32), .DW(8), .POLY(32'h04C11DB7)) u_c328 (
    .clk(clk), .rst(rst), .data_vld(vld), .data_in(d8b), .crc_out(q328));
  crc_par_step #(.PW(16), .DW(1), .POLY(16'h1021)) u_c16 (
    .clk(clk), .rst(rst), .data_vld(vld), .data_in(d1), .crc_out(q16));

  // Reference: walk data bits from the top down, one register shift each.
  function automatic logic [31:0] ref_word(input logic [31:0] cur, input logic [31:0] data,
                                           input int pw, input int dw, input logic [31:0] poly);
    logic [31:0] r;
    logic [31:0] keep;
    r    = cur;
    keep = (pw == 32) ? 32'hFFFF_FFFF : ((32'd1 << pw) - 32'd1);
    for (int i = dw - 1; i >= 0; i--) begin
      logic top;
      top = r[pw-1];
      r   = (r << 1) & keep;
      if (top ^ data[i]) r = r ^ (poly & keep);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, q32, m32);
    chk({req, " N5M8"}, {27'd0, q5}, m5);
    chk({req, " N32M8"}, q328, m328);
    chk({req, " N16M1"}, {16'd0, q16}, m16);
  endtask

  // Drive on the falling edge, let one rising edge act, look on the next falling edge.
  task automatic step(input logic v, input logic r, input logic [31:0] w);
    vld = v; rst = r;
    d32 = w; d8a = w[7:0]; d8b = w[15:8]; d1 = w[0];
    @(posedge clk);
    if (r) begin
      m32 = '1; m5 = 32'h1F; m328 = '1; m16 = 32'hFFFF;
    end else if (v) begin
      m32  = ref_word(m32,  w,                 32, 32, 32'h04C11DB7);
      m5   = ref_word(m5,   {24'd0, w[7:0]},   5,  8,  32'h05);
      m328 = ref_word(m328, {24'd0, w[15:8]},  32, 8,  32'h04C11DB7);
      m16  = ref_word(m16,  {31'd0, w[0]},     16, 1,  32'h1021);
    end
    @(negedge clk);
  endtask

  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF, 32'h8000_0001,
    32'h0F0F_F0F0, 32'hA5A5_5A5A, 32'h0000_0080, 32'h7FFF_FFFE, 32'hC3C3_3C3C
  };

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m32 = '0; m5 = '0; m328 = '0; m16 = '0;
    @(negedge clk);
    step(1'b0, 1'b1, 32'h0);
    step(1'b0, 1'b1, 32'h0);
    check_all("R1 reset ones");

    // R3 R5 R6 R7: vector table, back-to-back valid words
    for (int i = 0; i < NV; i++) begin
      step(1'b1, 1'b0, VEC[i]);
      check_all("R3 R6 table");
    end

    // R2: data toggles while valid is low
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 32'hFFFF_0000 ^ (32'h1111_1111 * i));
      check_all("R2 hold");
    end

    // R4: one-hot words at each end of the bus
    step(1'b1, 1'b0, 32'h8000_0000);
    check_all("R4 top bit first");
    step(1'b1, 1'b0, 32'h0000_0001);
    check_all("R4 bottom bit last");
    step(1'b1, 1'b0, 32'h0000_0080);
    check_all("R4 byte top bit");

    // R5: small polynomial from a known state, zero and all-ones bytes
    step(1'b0, 1'b1, 32'h0);
    step(1'b1, 1'b0, 32'h0000_0000);
    check_all("R5 poly zero byte");
    step(1'b1, 1'b0, 32'h0000_00FF);
    check_all("R5 poly ones byte");

    // R1: reset wins over a valid word
    step(1'b1, 1'b1, 32'h5555_AAAA);
    check_all("R1 reset over valid");

    // R7 R3: random traffic with idle gaps
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      logic v;
      w = $urandom;
      v = ($urandom % 4) != 0;
      step(v, 1'b0, w);
      check_all("R7 R3 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule